// File: doc/BRIEF.md
# Display Register Command Decoder

This block sits behind a byte-wide stream, such as the output of a bulk-transfer receive FIFO. It recognises fixed four-byte register write commands and loads the values into a small register file of display settings. The settings are the two frame-store base pointers, the colour-depth select, twelve 16-bit raster timing compare values, the pixel clock in 5 kHz units, and the sync and power control byte. All of them are driven out continuously to the raster logic.

The host groups timing updates with a lock command and an unlock command. While the bank is locked, writes collect in a staging copy, and the outputs do not change. The unlock command copies the whole staging copy onto the outputs in one cycle, so the raster logic never sees a mix of old and new timing.

The block also enforces one power rule. Once the output is in deep power-down, it can only return through a locked update that rewrites timing.

Top module: `regcmd_decoder`

## Requirements
- R1: A command is exactly four accepted bytes: 0xAF, 0x20, an address byte, then a value byte. The write shows on the outputs after the clock edge that accepts the value byte.
- R2: A byte other than 0xAF is dropped when a command should start, and the decoder keeps searching. If the second byte is not 0x20, that byte is consumed, the command is abandoned and nothing is written.
- R3: `in_ready_o` is high at all times except for exactly one cycle. That cycle follows the acceptance of the last byte of an unlock command.
- R4: Writing value 0x00 to address 0xFF locks the bank and raises `locked_o`. After that, writes go only to the staging copy, and every settings output holds its value.
- R5: Writing value 0xFF to address 0xFF copies every staged value to the outputs together, at the end of the ready-low cycle, and clears `locked_o`. Any other value written to 0xFF is ignored.
- R6: While unlocked, a write updates the outputs directly and the staging copy as well.
- R7: Timing register i (0 to 11) takes its high byte at address 0x01+2i and its low byte at 0x02+2i. It appears on `timing_o[16i+15:16i]`.
- R8: The pixel clock register takes its low byte at 0x1B and its high byte at 0x1C.
- R9: The 16bpp base pointer is written at 0x20, 0x21, 0x22 and the 8bpp base pointer at 0x26, 0x27, 0x28. In each group the most significant byte comes first.
- R10: Bit 0 of a write to 0x00 sets `depth24_o`. A value of 0 selects 16 bpp and 1 selects 24 bpp.
- R11: Address 0x1F holds the sync byte: 0x00 enables both syncs, 0x01 blanks with power on, and 0x07 powers down. After reset the sync byte is 0x01, every other setting is 0, the bank is unlocked and `in_ready_o` is high.
- R12: While the output sync byte is 0x07, it can change only at an unlock. The locked window before that unlock must contain a write to a timing address (0x01 to 0x18); otherwise the sync byte stays 0x07 and the other staged values still take effect.
- R13: Writes to addresses that map to no setting change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Block accepts a byte this cycle |
| locked_o | output | 1 | Bank is locked; writes are being staged |
| depth24_o | output | 1 | 1 = 24 bpp, 0 = 16 bpp |
| ptr16_o | output | 24 | 16bpp frame-store base pointer |
| ptr8_o | output | 24 | 8bpp frame-store base pointer |
| timing_o | output | 192 | Twelve 16-bit timing compare values, register i at bits 16i+15:16i |
| pclk_o | output | 16 | Pixel clock in 5 kHz units |
| sync_ctl_o | output | 8 | Sync and power control byte |

## Verification
The bench starts with directed cases.
- Single unlocked writes to each register family show whether the byte order is right for the big-endian timing and pointer registers and for the little-endian pixel clock.
- Stray bytes and abandoned commands, placed just before valid commands, separate a correct resynchronisation from one that loses or misaligns the next command.
- Locked sequences with and without a timing write, run from the power-down state, separate the gated exit from an exit that happens too eagerly or not at all.

A seeded random mix of writes, locks, unlocks, no-op lock values, garbage and aborted frames then runs against a byte-addressed reference model. This exposes staging and ordering slips that the directed cases do not reach.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

  localparam int unsigned NUM_TIM = 12;
  localparam int unsigned TIM_W   = 16;
  localparam int unsigned PTR_W   = 24;
  localparam int unsigned PTR_B   = PTR_W / 8;

  localparam logic [7:0] SYNC_BYTE  = 8'hAF;
  localparam logic [7:0] OPC_WRITE  = 8'h20;
  localparam logic [7:0] A_LOCK     = 8'hFF;
  localparam logic [7:0] V_LOCK     = 8'h00;
  localparam logic [7:0] V_UNLOCK   = 8'hFF;
  localparam logic [7:0] A_DEPTH    = 8'h00;
  localparam logic [7:0] A_TIM0     = 8'h01;
  localparam logic [7:0] A_PCLK_LO  = 8'h1B;
  localparam logic [7:0] A_PCLK_HI  = 8'h1C;
  localparam logic [7:0] A_SYNC     = 8'h1F;
  localparam logic [7:0] A_PTR16    = 8'h20;
  localparam logic [7:0] A_PTR8     = 8'h26;
  localparam logic [7:0] SYNC_PWRDN = 8'h07;
  localparam logic [7:0] SYNC_RST   = 8'h01;

  typedef enum logic [2:0] {
    ST_HUNT, ST_OPC, ST_ADDR, ST_DATA, ST_COMMIT
  } frm_state_e;

  typedef struct packed {
    logic                             depth24;
    logic [PTR_W-1:0]                 ptr16;
    logic [PTR_W-1:0]                 ptr8;
    logic [NUM_TIM-1:0][TIM_W-1:0]    tim;
    logic [15:0]                      pclk;
    logic [7:0]                       sync;
  } regset_t;

  function automatic regset_t regs_reset();
    regset_t r;
    r      = '0;
    r.sync = SYNC_RST;
    return r;
  endfunction

  function automatic logic is_timing(logic [7:0] a);
    return (a >= A_TIM0) && (a < A_TIM0 + 8'(2 * NUM_TIM));
  endfunction

  // Big-endian timing and pointer groups, little-endian pixel clock.
  function automatic regset_t apply_write(regset_t r, logic [7:0] a, logic [7:0] d);
    regset_t n;
    n = r;
    if (a == A_DEPTH)   n.depth24   = d[0];
    if (a == A_PCLK_LO) n.pclk[7:0] = d;
    if (a == A_PCLK_HI) n.pclk[15:8] = d;
    if (a == A_SYNC)    n.sync      = d;
    for (int unsigned i = 0; i < NUM_TIM; i++) begin
      if (a == A_TIM0 + 8'(2 * i))     n.tim[i][15:8] = d;
      if (a == A_TIM0 + 8'(2 * i + 1)) n.tim[i][7:0]  = d;
    end
    for (int unsigned k = 0; k < PTR_B; k++) begin
      if (a == A_PTR16 + 8'(k)) n.ptr16[PTR_W-1-8*k -: 8] = d;
      if (a == A_PTR8 + 8'(k))  n.ptr8[PTR_W-1-8*k -: 8]  = d;
    end
    return n;
  endfunction

endpackage

// File: rtl/rc_framer.sv
module rc_framer
  import regcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  output logic       in_ready_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       commit_o
);

  frm_state_e state_q, state_d;
  logic [7:0] addr_q;
  logic       addr_en;
  logic       accept;

  assign in_ready_o = (state_q != ST_COMMIT);
  assign accept     = in_valid_i && in_ready_o;
  assign commit_o   = (state_q == ST_COMMIT);
  assign wr_en_o    = accept && (state_q == ST_DATA);
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = in_data_i;
  assign addr_en    = accept && (state_q == ST_ADDR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT:   if (accept && in_data_i == SYNC_BYTE) state_d = ST_OPC;
      ST_OPC:    if (accept) state_d = (in_data_i == OPC_WRITE) ? ST_ADDR : ST_HUNT;
      ST_ADDR:   if (accept) state_d = ST_DATA;
      ST_DATA:   if (accept) state_d = (addr_q == A_LOCK && in_data_i == V_UNLOCK)
                                       ? ST_COMMIT : ST_HUNT;
      ST_COMMIT: state_d = ST_HUNT;
      default:   state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q <= in_data_i;
    end
  end

endmodule

// File: rtl/rc_regbank.sv
module rc_regbank
  import regcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       commit_i,
  output regset_t    active_o,
  output logic       locked_o
);

  regset_t shadow_q, shadow_d;
  regset_t active_q, active_d;
  logic    locked_q, locked_d;
  logic    tdirty_q, tdirty_d;
  logic    shadow_en, active_en, ctl_en;
  logic    in_pwrdn;

  assign in_pwrdn  = (active_q.sync == SYNC_PWRDN);
  assign shadow_en = wr_en_i;
  assign active_en = (wr_en_i && !locked_q) || commit_i;
  assign ctl_en    = wr_en_i || commit_i;

  always_comb begin
    shadow_d = shadow_q;
    active_d = active_q;
    locked_d = locked_q;
    tdirty_d = tdirty_q;
    if (wr_en_i) begin
      shadow_d = apply_write(shadow_q, wr_addr_i, wr_data_i);
      if (locked_q && is_timing(wr_addr_i)) tdirty_d = 1'b1;
      if (!locked_q) begin
        active_d = apply_write(active_q, wr_addr_i, wr_data_i);
        if (in_pwrdn) active_d.sync = SYNC_PWRDN;
      end
      if (wr_addr_i == A_LOCK && wr_data_i == V_LOCK) locked_d = 1'b1;
    end
    if (commit_i) begin
      active_d = shadow_q;
      if (in_pwrdn && !tdirty_q) active_d.sync = SYNC_PWRDN;
      locked_d = 1'b0;
      tdirty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= regs_reset();
      active_q <= regs_reset();
      locked_q <= 1'b0;
      tdirty_q <= 1'b0;
    end else begin
      if (shadow_en) shadow_q <= shadow_d;
      if (active_en) active_q <= active_d;
      if (ctl_en) begin
        locked_q <= locked_d;
        tdirty_q <= tdirty_d;
      end
    end
  end

  assign active_o = active_q;
  assign locked_o = locked_q;

endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder
  import regcmd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid_i,
  input  logic [7:0]               in_data_i,
  output logic                     in_ready_o,
  output logic                     locked_o,
  output logic                     depth24_o,
  output logic [PTR_W-1:0]         ptr16_o,
  output logic [PTR_W-1:0]         ptr8_o,
  output logic [NUM_TIM*TIM_W-1:0] timing_o,
  output logic [15:0]              pclk_o,
  output logic [7:0]               sync_ctl_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       wr_en, commit;
  logic [7:0] wr_addr, wr_data;
  regset_t    act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  rc_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_ready_o (in_ready_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .commit_o   (commit)
  );

  rc_regbank u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .commit_i  (commit),
    .active_o  (act),
    .locked_o  (locked_o)
  );

  assign depth24_o  = act.depth24;
  assign ptr16_o    = act.ptr16;
  assign ptr8_o     = act.ptr8;
  assign timing_o   = act.tim;
  assign pclk_o     = act.pclk;
  assign sync_ctl_o = act.sync;

endmodule

// File: rtl/regcmd_decoder_chk.sv
module regcmd_decoder_chk
  import regcmd_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid_i,
  input logic [7:0]               in_data_i,
  input logic                     in_ready_o,
  input logic                     locked_o,
  input logic                     depth24_o,
  input logic [PTR_W-1:0]         ptr16_o,
  input logic [PTR_W-1:0]         ptr8_o,
  input logic [NUM_TIM*TIM_W-1:0] timing_o,
  input logic [15:0]              pclk_o,
  input logic [7:0]               sync_ctl_o
);

  p_ready_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready_o |=> in_ready_o);

  p_commit_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready_o |=> !locked_o);

  p_hold_while_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && in_ready_o) |=> ($stable(ptr16_o) && $stable(ptr8_o) &&
      $stable(timing_o) && $stable(pclk_o) && $stable(sync_ctl_o) && $stable(depth24_o)));

  p_lock_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(in_valid_i && in_ready_o && in_data_i == V_LOCK));

  p_pwrdn_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ctl_o == SYNC_PWRDN && in_ready_o) |=> sync_ctl_o == SYNC_PWRDN);

endmodule

bind regcmd_decoder regcmd_decoder_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid_i (in_valid_i),
  .in_data_i  (in_data_i),
  .in_ready_o (in_ready_o),
  .locked_o   (locked_o),
  .depth24_o  (depth24_o),
  .ptr16_o    (ptr16_o),
  .ptr8_o     (ptr8_o),
  .timing_o   (timing_o),
  .pclk_o     (pclk_o),
  .sync_ctl_o (sync_ctl_o)
);

// File: tb/regcmd_decoder_tb_top.sv
`timescale 1ns/1ps
module regcmd_decoder_tb_top;

  localparam int NT = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid_i;
  logic [7:0]    in_data_i;
  logic          in_ready_o;
  logic          locked_o;
  logic          depth24_o;
  logic [23:0]   ptr16_o;
  logic [23:0]   ptr8_o;
  logic [NT*16-1:0] timing_o;
  logic [15:0]   pclk_o;
  logic [7:0]    sync_ctl_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0] sh [256];
  logic [7:0] ac [256];
  logic       m_locked;
  logic       m_dirty;

  always #2 clk = ~clk;

  regcmd_decoder dut_i (
    .clk (clk), .rst_n (rst_n), .in_valid_i (in_valid_i), .in_data_i (in_data_i),
    .in_ready_o (in_ready_o), .locked_o (locked_o), .depth24_o (depth24_o),
    .ptr16_o (ptr16_o), .ptr8_o (ptr8_o), .timing_o (timing_o),
    .pclk_o (pclk_o), .sync_ctl_o (sync_ctl_o)
  );

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [NT*16-1:0] exp_tim();
    logic [NT*16-1:0] r;
    for (int i = 0; i < NT; i++) r[16*i +: 16] = {ac[1+2*i], ac[2+2*i]};
    return r;
  endfunction

  task automatic check_outputs(input string req);
    check({req, " R7 timing"}, timing_o, exp_tim());
    check({req, " R8 pclk"}, pclk_o, {ac[8'h1C], ac[8'h1B]});
    check({req, " R9 ptr16"}, ptr16_o, {ac[8'h20], ac[8'h21], ac[8'h22]});
    check({req, " R9 ptr8"}, ptr8_o, {ac[8'h26], ac[8'h27], ac[8'h28]});
    check({req, " R10 depth"}, depth24_o, ac[8'h00][0]);
    check({req, " R11 sync"}, sync_ctl_o, ac[8'h1F]);
    check({req, " R4 locked"}, locked_o, m_locked);
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready_o) @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i  = b;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic model_commit();
    logic [7:0] old_sync;
    old_sync = ac[8'h1F];
    for (int i = 0; i < 256; i++) ac[i] = sh[i];
    if (old_sync == 8'h07 && !m_dirty) ac[8'h1F] = 8'h07;
    m_locked = 1'b0;
    m_dirty  = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    put_byte(8'hAF); put_byte(8'h20); put_byte(a); put_byte(d);
    idle();
    if (a == 8'hFF) begin
      if (d == 8'h00) m_locked = 1'b1;
      if (d == 8'hFF) begin
        check("R3 ready low on commit", in_ready_o, 1'b0);
        @(negedge clk);
        model_commit();
        check("R3 ready back", in_ready_o, 1'b1);
      end
    end else begin
      sh[a] = d;
      if (m_locked && a >= 8'h01 && a <= 8'h18) m_dirty = 1'b1;
      if (!m_locked && !(a == 8'h1F && ac[8'h1F] == 8'h07)) ac[a] = d;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog got=timeout exp=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin sh[i] = 8'h00; ac[i] = 8'h00; end
    sh[8'h1F] = 8'h01; ac[8'h1F] = 8'h01;
    m_locked = 1'b0; m_dirty = 1'b0;
    in_valid_i = 1'b0; in_data_i = 8'h00; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 reset ready", in_ready_o, 1'b1);
    check_outputs("R11 reset");

    // R1 R6 R9 direct writes, byte order
    wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
    wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF);
    check("R9 ptr16 msb first", ptr16_o, 24'h123456);
    check("R6 R9 ptr8", ptr8_o, 24'hABCDEF);
    // R7 R8 R10
    wr(8'h03, 8'hBE); wr(8'h04, 8'hEF);
    check("R7 timing reg1", timing_o[31:16], 16'hBEEF);
    wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
    check("R8 pclk little endian", pclk_o, 16'h1234);
    wr(8'h00, 8'h01);
    check("R10 depth 24", depth24_o, 1'b1);
    check_outputs("R1");

    // R2 junk and aborted frames
    put_byte(8'h55); put_byte(8'h20); put_byte(8'h17); idle();
    put_byte(8'hAF); put_byte(8'h99); put_byte(8'h00); put_byte(8'h07); idle();
    check_outputs("R2 junk");
    wr(8'h18, 8'h5A);
    check("R2 resync", timing_o[191:176], {ac[8'h17], 8'h5A});

    // R4 R5 staged update
    wr(8'hFF, 8'h00);
    check("R4 locked", locked_o, 1'b1);
    wr(8'h01, 8'h77); wr(8'h02, 8'h88); wr(8'h22, 8'h99);
    check("R4 timing held", timing_o[15:0], 16'h0000);
    check_outputs("R4 held");
    wr(8'hFF, 8'h55);
    check("R5 other value ignored", locked_o, 1'b1);
    wr(8'hFF, 8'hFF);
    check("R5 committed", timing_o[15:0], 16'h7788);
    check("R5 ptr committed", ptr16_o, 24'h123499);
    check_outputs("R5 commit");

    // R13 unmapped addresses
    wr(8'h19, 8'hFF); wr(8'h40, 8'h11); wr(8'h23, 8'h66);
    check_outputs("R13 unmapped");

    // R12 power-down exit rule
    wr(8'h1F, 8'h07);
    check("R11 powerdown", sync_ctl_o, 8'h07);
    wr(8'h1F, 8'h00);
    check("R12 direct exit blocked", sync_ctl_o, 8'h07);
    wr(8'hFF, 8'h00); wr(8'h1F, 8'h00); wr(8'h20, 8'h01); wr(8'hFF, 8'hFF);
    check("R12 no timing exit blocked", sync_ctl_o, 8'h07);
    check("R12 others commit", ptr16_o[23:16], 8'h01);
    wr(8'hFF, 8'h00); wr(8'h1F, 8'h00); wr(8'h09, 8'h42); wr(8'hFF, 8'hFF);
    check("R12 exit with timing", sync_ctl_o, 8'h00);
    check_outputs("R12");

    // random mix, R4 R5 R6 against model
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [7:0] a, d;
      sel = int'($urandom % 16);
      d = 8'($urandom);
      if (sel == 0) begin
        put_byte((d == 8'hAF) ? 8'h00 : d); idle();
      end else if (sel == 1) begin
        put_byte(8'hAF); put_byte((d == 8'h20) ? 8'h21 : d); idle();
      end else if (sel == 2) wr(8'hFF, 8'h00);
      else if (sel == 3) wr(8'hFF, 8'hFF);
      else if (sel == 4) wr(8'hFF, (d == 8'h00 || d == 8'hFF) ? 8'h5A : d);
      else if (sel == 5) begin
        case ($urandom % 3) 0: d = 8'h00; 1: d = 8'h01; default: d = 8'h07; endcase
        wr(8'h1F, d);
      end else begin
        a = 8'($urandom % 48);
        wr(a, d);
      end
      check_outputs("R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule